// File: doc/BRIEF.md
# Seven-Input Population Counter with Late Seventh Bit

This block is a purely combinational 7:3 counter. It takes seven bits of equal weight and returns their count of ones as a 3-bit binary number. It is meant for column compression in a multiplier's partial-product tree, where one input of the column often settles later than the rest.

The six early bits form two three-bit stacks. A stack of three bits holds three flags: at least one bit set, at least two bits set, and all three bits set. Threshold flags for the six-bit count are taken from pairs of these stack flags. The weight-two and weight-four outputs are each built twice, once for the late bit clear and once for it set. The late bit then drives a 2:1 multiplexer that picks one candidate of each pair. The weight-one output is the six-bit parity XORed with the late bit. Because of this, the late bit passes through only one multiplexer or one XOR before it reaches the outputs.

Top module: `pop7_late_select`

## Requirements
- R1: `count_o` equals the number of ones in `bits_i` for all 128 input patterns. Bit 2 of `count_o` has weight four, bit 1 has weight two and bit 0 has weight one.
- R2: `count_o[0]` equals the XOR of all seven input bits.
- R3: When `bits_i[6]` is 0, `count_o` equals the number of ones in `bits_i[5:0]`.
- R4: When `bits_i[6]` is 1, `count_o[1]` is 1 exactly when the number of ones in `bits_i[5:0]` is 1, 2, 5 or 6.
- R5: When `bits_i[6]` is 1, `count_o[2]` is 1 exactly when the number of ones in `bits_i[5:0]` is 3 or more.
- R6: `count_o` is 3'b111 only when all seven input bits are 1.
- R7: An all-zero input gives `count_o` = 3'b000.
- R8: For any fixed `bits_i[5:0]`, the count with `bits_i[6]` = 1 is exactly one more than the count with `bits_i[6]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bits_i | input | 7 | Bits of equal weight. Bit 6 is the late-arriving bit. |
| count_o | output | 3 | Binary count of ones in `bits_i`. |

## Verification
The checker has no clock, so its assertions assume that `bits_i` is always a known, two-valued vector. They compare the settled output against the input's popcount each time the input changes. The bench drives only fully specified seven-bit patterns. It holds each pattern for a whole clock period and reads the output half a period after driving it, so the assertions and the checks never see a pattern that is only partly applied.

// File: rtl/pop7_late_select.sv
module pop7_late_select (
  input  logic [6:0] bits_i,
  output logic [2:0] count_o
);

  function automatic logic [2:0] stack3(input logic [2:0] v);
    return {&v, (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]), |v};
  endfunction

  logic [2:0] hs, is, jv, kv;
  logic       late;
  logic       ge1, ge2, ge3, ge4, ge5, ge6;
  logic       c1_lo, c2_lo, c1_hi, c2_hi, s6;

  assign late = bits_i[6];
  assign hs   = stack3(bits_i[2:0]);
  assign is   = stack3(bits_i[5:3]);

  assign jv = {hs[2] | is[0], hs[1] | is[1], hs[0] | is[2]};
  assign kv = {hs[2] & is[0], hs[1] & is[1], hs[0] & is[2]};

  assign ge1 = hs[0] | is[0];
  assign ge2 = hs[1] | is[1] | (hs[0] & is[0]);
  assign ge3 = &jv;
  assign ge4 = |kv;
  assign ge5 = (hs[2] & is[1]) | (hs[1] & is[2]);
  assign ge6 = hs[2] & is[2];

  assign c1_lo = (ge2 & ~ge4) | ge6;
  assign c2_lo = ge4;
  assign c1_hi = (ge1 & ~ge3) | ge5;
  assign c2_hi = ge3;

  assign s6 = ((hs[0] & ~hs[1]) | hs[2]) ^ ((is[0] & ~is[1]) | is[2]);

  assign count_o = {late ? c2_hi : c2_lo, late ? c1_hi : c1_lo, s6 ^ late};

endmodule

// File: rtl/pop7_late_select_chk.sv
module pop7_late_select_chk (
  input logic [6:0] bits_i,
  input logic [2:0] count_o
);

  always_comb begin
    p_popcount_r1: assert (count_o == 3'($countones(bits_i)));
    p_parity_r2:   assert (count_o[0] == ^bits_i);
    p_low_only_r3: assert (bits_i[6] || count_o == 3'($countones(bits_i[5:0])));
    p_c1_late_r4:  assert (!bits_i[6] || count_o[1] ==
                           ($countones(bits_i[5:0]) inside {1, 2, 5, 6}));
    p_c2_late_r5:  assert (!bits_i[6] || count_o[2] == ($countones(bits_i[5:0]) >= 3));
    p_full_r6:     assert ((count_o == 3'b111) == (&bits_i));
    p_zero_r7:     assert ((bits_i != 7'd0) || (count_o == 3'b000));
  end

endmodule

bind pop7_late_select pop7_late_select_chk u_chk (
  .bits_i (bits_i),
  .count_o(count_o)
);

// File: tb/pop7_late_select_tb.sv
module pop7_late_select_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bits_i = 7'd0;
  logic [2:0] count_o;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  localparam int NDIR = 15;
  localparam logic [9:0] DIR [NDIR] = '{
    {7'h00, 3'd0}, {7'h7F, 3'd7}, {7'h3F, 3'd6}, {7'h40, 3'd1}, {7'h01, 3'd1},
    {7'h41, 3'd2}, {7'h07, 3'd3}, {7'h47, 3'd4}, {7'h0F, 3'd4}, {7'h1F, 3'd5},
    {7'h5F, 3'd6}, {7'h38, 3'd3}, {7'h78, 3'd4}, {7'h2A, 3'd3}, {7'h55, 3'd4}
  };

  always #4 clk = ~clk;

  pop7_late_select u_dut (.bits_i(bits_i), .count_o(count_o));

  task automatic apply(input logic [6:0] v);
    @(posedge clk);
    bits_i = v;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] v,
                       input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s in=%07b actual=%03b expected=%03b", req, v, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog in=%07b actual=%03b expected=---", bits_i, count_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset state", bits_i, count_o, 3'd0);

    for (int i = 0; i < NDIR; i++) begin
      apply(DIR[i][9:3]);
      check("R1 directed", bits_i, count_o, DIR[i][2:0]);
    end

    for (int v = 0; v < 128; v++) begin
      logic [6:0] p;
      int lo;
      p  = 7'(v);
      lo = $countones(p[5:0]);
      apply(p);
      check("R1 exhaustive", p, count_o, 3'($countones(p)));
      check("R2 parity", p, {2'b00, count_o[0]}, {2'b00, ^p});
      if (!p[6]) check("R3 late clear", p, count_o, 3'(lo));
      else begin
        check("R4 c1 late set", p, {2'b00, count_o[1]},
              {2'b00, (lo == 1 || lo == 2 || lo == 5 || lo == 6)});
        check("R5 c2 late set", p, {2'b00, count_o[2]}, {2'b00, (lo >= 3)});
      end
      if (count_o == 3'b111) check("R6 full only", p, {2'b00, &p}, 3'd1);
    end

    for (int v = 0; v < 64; v++) begin
      logic [2:0] c0;
      apply({1'b0, 6'(v)});
      c0 = count_o;
      apply({1'b1, 6'(v)});
      check("R8 late step", bits_i, count_o, c0 + 3'd1);
    end

    apply(7'h7F);
    check("R6 all ones", bits_i, count_o, 3'b111);
    apply(7'h00);
    check("R7 all zero", bits_i, count_o, 3'b000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule